// File: doc/BRIEF.md
# Segmented Branch and Fetch-Address Unit

This block holds the code segment and the instruction pointer of a 16-bit segmented processor. It turns them into a 20-bit physical instruction-fetch address. It also forms the 20-bit address of the current operand access from a chosen segment register and a 16-bit offset. The physical address is the segment value multiplied by 16 plus the offset, with any carry above bit 19 dropped, so segment bases sit 16 bytes apart across a 1 MB space.

Control flow changes in three ways. A sequential advance moves the instruction pointer forward by the length of the instruction. A near branch loads only the pointer and keeps the code segment. A far branch loads both registers on the same clock edge. A branch target can be given directly on the request, or it can be memory-indirect. For an indirect target, the unit reads the new offset, and for a far branch also the new segment, through a single-port read handshake before it changes control. While it does this it raises `busy` and ignores any other request.

Top module: `seg_branch_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the code segment becomes 16'hFFFF and the pointer becomes 16'h0000, and `busy` and `mem_req` read 0 after that edge.
- R2: `fetch_addr` always equals (`cs_out` * 16 + `ip_out`) mod 2^20.
- R3: `op_addr` equals (segment * 16 + `op_off`) mod 2^20. The segment is `seg_ds` when `ovr_en` is 0. When `ovr_en` is 1, `ovr_sel` picks it: 2'b00 `seg_es`, 2'b01 the code segment, 2'b10 `seg_ss`, 2'b11 `seg_ds`.
- R4: An accepted advance (`adv_valid` with `br_valid` low and `busy` low) sets the pointer to (pointer + `adv_len`) mod 2^16 at that edge and leaves the code segment unchanged.
- R5: An accepted near direct branch (`br_valid`, `br_far`=0, `br_indirect`=0) loads the pointer with `br_off` at that edge and leaves the code segment unchanged.
- R6: An accepted far direct branch (`br_far`=1, `br_indirect`=0) loads the code segment with `br_seg` and the pointer with `br_off` on the same edge.
- R7: An accepted near indirect branch reads one word. The read address uses the operand segment chosen by the R3 rule, captured when the branch is accepted, with `br_off` as the offset. The pointer then takes the returned word on the edge where `mem_ack` is sampled high, and the code segment is unchanged.
- R8: An accepted far indirect branch first reads the offset word at the pointer address. It then reads the segment word at the same segment with offset (`br_off` + 2) mod 2^16. Both registers are loaded together on the edge that acknowledges the second read, and neither changes before that edge.
- R9: `busy` is high from the cycle after an indirect branch is accepted until the registers are loaded. `mem_req` is high only while busy, and `mem_addr` holds steady until `mem_ack` is seen.
- R10: Branch and advance requests presented while `busy` is high have no effect on the code segment or the pointer.
- R11: When `br_valid` and `adv_valid` are both high and the unit is idle, the branch is taken and the advance is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adv_valid | input | 1 | Sequential advance request |
| adv_len | input | 4 | Instruction length in bytes added on advance |
| br_valid | input | 1 | Branch request |
| br_far | input | 1 | 1: load segment and offset; 0: offset only |
| br_indirect | input | 1 | 1: target fetched from memory; 0: target on the ports |
| br_off | input | 16 | Direct target offset, or pointer offset for indirect |
| br_seg | input | 16 | Direct far target segment |
| op_off | input | 16 | Operand offset |
| ovr_en | input | 1 | Segment override enable |
| ovr_sel | input | 2 | Override segment select (00 ES, 01 CS, 10 SS, 11 DS) |
| seg_es | input | 16 | Extra segment value |
| seg_ss | input | 16 | Stack segment value |
| seg_ds | input | 16 | Data segment value |
| mem_req | output | 1 | Indirect target read request |
| mem_addr | output | 20 | Indirect target read address |
| mem_ack | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 16 | Read data word |
| fetch_addr | output | 20 | Physical instruction-fetch address |
| op_addr | output | 20 | Physical operand address |
| cs_out | output | 16 | Current code segment |
| ip_out | output | 16 | Current instruction pointer |
| busy | output | 1 | Indirect target fetch in progress |

## Verification
Random sequences mix advances, near and far direct branches, coincident branch-plus-advance requests and indirect branches of both sizes. A near/far mix-up shows as a segment that changes when it should not, or that fails to change. The segment registers, the override select and the operand offset are randomized every cycle. This separates the default data segment from each override code and catches segment values that are latched at the wrong time. Directed cases push the advance past 16'hFFFF, place a fetch address above the 20-bit range, put an indirect pointer at offset 16'hFFFF so the second word wraps within its segment, and use varying acknowledge delays with junk requests while busy. These cases catch carries that are not dropped, a wrong word order and requests that leak through.

// File: rtl/seg_branch_pkg.sv
// Shared constants and types for the segmented branch and fetch-address unit.
// Assumes a 16-bit offset space and a 20-bit physical space.
package seg_branch_pkg;
    localparam int OFF_W = 16;
    localparam int PA_W  = 20;

    // Override select codes; the operand path decodes these values
    typedef enum logic [1:0] {
        SEG_ES = 2'b00,
        SEG_CS = 2'b01,
        SEG_SS = 2'b10,
        SEG_DS = 2'b11
    } seg_sel_e;

    // Indirect target sequencer states
    typedef enum logic [1:0] {
        FS_IDLE   = 2'b00,
        FS_RD_OFF = 2'b01,
        FS_RD_SEG = 2'b10
    } fetch_state_e;
endpackage

// File: rtl/seg_addr_gen.sv
// Physical address former: segment * 2^(PA_W-OFF_W) + offset, truncated to PA_W.
// Assumes PA_W > OFF_W; carries beyond PA_W bits are discarded.
module seg_addr_gen #(
    parameter int OFF_W = 16,
    parameter int PA_W  = 20
) (
    input  logic [OFF_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [PA_W-1:0]  phys
);
    localparam int SHIFT = PA_W - OFF_W;

    logic [PA_W-1:0] base;
    logic [PA_W-1:0] off_ext;

    // Form shifted base and zero-extended offset, sum wraps at PA_W bits
    always_comb begin
        base    = {seg, {SHIFT{1'b0}}};
        off_ext = {{SHIFT{1'b0}}, off};
        phys    = base + off_ext;
    end
endmodule

// File: rtl/seg_op_select.sv
// Operand segment selector: data segment by default, override picks one of four.
// Assumes the select code values from seg_branch_pkg.
module seg_op_select
    import seg_branch_pkg::*;
#(
    parameter int OFF_W = 16
) (
    input  logic             ovr_en,
    input  logic [1:0]       ovr_sel,
    input  logic [OFF_W-1:0] cs_val,
    input  logic [OFF_W-1:0] es_val,
    input  logic [OFF_W-1:0] ss_val,
    input  logic [OFF_W-1:0] ds_val,
    output logic [OFF_W-1:0] seg
);
    // Choose the operand segment value
    always_comb begin
        seg = ds_val;
        if (ovr_en) begin
            unique case (seg_sel_e'(ovr_sel))
                SEG_ES:  seg = es_val;
                SEG_CS:  seg = cs_val;
                SEG_SS:  seg = ss_val;
                default: seg = ds_val;
            endcase
        end
    end
endmodule

// File: rtl/seg_ind_seq.sv
// Indirect target sequencer: reads the offset word and, for far targets, the
// segment word at offset+2, then issues one load to the register file.
// Assumes mem_ack is only meaningful while mem_req is high.
module seg_ind_seq
    import seg_branch_pkg::*;
#(
    parameter int OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_far,
    input  logic [OFF_W-1:0] ptr_seg,
    input  logic [OFF_W-1:0] ptr_off,
    input  logic             mem_ack,
    input  logic [OFF_W-1:0] mem_rdata,
    output logic             mem_req,
    output logic [OFF_W-1:0] mem_seg,
    output logic [OFF_W-1:0] mem_off,
    output logic             busy,
    output logic             load_ip,
    output logic             load_cs,
    output logic [OFF_W-1:0] new_ip,
    output logic [OFF_W-1:0] new_cs
);
    localparam logic [OFF_W-1:0] WORD_STEP = OFF_W'(2);

    fetch_state_e     state_q;
    logic             far_q;
    logic [OFF_W-1:0] pseg_q;
    logic [OFF_W-1:0] poff_q;
    logic [OFF_W-1:0] tmp_off_q;

    // State, pointer capture and first-word holding register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= FS_IDLE;
            far_q     <= 1'b0;
            pseg_q    <= '0;
            poff_q    <= '0;
            tmp_off_q <= '0;
        end else begin
            unique case (state_q)
                FS_IDLE: if (start) begin
                    state_q <= FS_RD_OFF;
                    far_q   <= start_far;
                    pseg_q  <= ptr_seg;
                    poff_q  <= ptr_off;
                end
                FS_RD_OFF: if (mem_ack) begin
                    tmp_off_q <= mem_rdata;
                    state_q   <= far_q ? FS_RD_SEG : FS_IDLE;
                end
                FS_RD_SEG: if (mem_ack) state_q <= FS_IDLE;
                default: state_q <= FS_IDLE;
            endcase
        end
    end

    // Read request, address and register load outputs
    always_comb begin
        busy    = (state_q != FS_IDLE);
        mem_req = busy;
        mem_seg = pseg_q;
        mem_off = (state_q == FS_RD_SEG) ? poff_q + WORD_STEP : poff_q;
        load_ip = 1'b0;
        load_cs = 1'b0;
        new_ip  = mem_rdata;
        new_cs  = mem_rdata;
        if (state_q == FS_RD_OFF && mem_ack && !far_q) begin
            load_ip = 1'b1;
        end
        if (state_q == FS_RD_SEG && mem_ack) begin
            load_ip = 1'b1;
            load_cs = 1'b1;
            new_ip  = tmp_off_q;
        end
    end
endmodule

// File: rtl/seg_branch_unit.sv
// Top: code segment and instruction pointer registers, fetch and operand
// address forming, direct branches, advances and indirect target fetch.
// Assumes a single requester; requests while busy are dropped.
module seg_branch_unit
    import seg_branch_pkg::*;
#(
    parameter int               LEN_W  = 4,
    parameter logic [OFF_W-1:0] RST_CS = 16'hFFFF,
    parameter logic [OFF_W-1:0] RST_IP = 16'h0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_valid,
    input  logic [LEN_W-1:0] adv_len,
    input  logic             br_valid,
    input  logic             br_far,
    input  logic             br_indirect,
    input  logic [OFF_W-1:0] br_off,
    input  logic [OFF_W-1:0] br_seg,
    input  logic [OFF_W-1:0] op_off,
    input  logic             ovr_en,
    input  logic [1:0]       ovr_sel,
    input  logic [OFF_W-1:0] seg_es,
    input  logic [OFF_W-1:0] seg_ss,
    input  logic [OFF_W-1:0] seg_ds,
    output logic             mem_req,
    output logic [PA_W-1:0]  mem_addr,
    input  logic             mem_ack,
    input  logic [OFF_W-1:0] mem_rdata,
    output logic [PA_W-1:0]  fetch_addr,
    output logic [PA_W-1:0]  op_addr,
    output logic [OFF_W-1:0] cs_out,
    output logic [OFF_W-1:0] ip_out,
    output logic             busy
);
    logic [OFF_W-1:0] cs_q, ip_q;
    logic [OFF_W-1:0] op_seg;
    logic [OFF_W-1:0] mem_seg, mem_off;
    logic             seq_load_ip, seq_load_cs;
    logic [OFF_W-1:0] seq_new_ip, seq_new_cs;
    logic             take_br, take_direct, take_ind, take_adv;

    // Request acceptance, branch before advance, nothing while busy
    always_comb begin
        take_br     = br_valid && !busy;
        take_direct = take_br && !br_indirect;
        take_ind    = take_br && br_indirect;
        take_adv    = adv_valid && !br_valid && !busy;
    end

    // Code segment and pointer update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= RST_CS;
            ip_q <= RST_IP;
        end else if (seq_load_ip) begin
            ip_q <= seq_new_ip;
            if (seq_load_cs) cs_q <= seq_new_cs;
        end else if (take_direct) begin
            ip_q <= br_off;
            if (br_far) cs_q <= br_seg;
        end else if (take_adv) begin
            ip_q <= ip_q + OFF_W'(adv_len);
        end
    end

    seg_op_select #(.OFF_W(OFF_W)) u_opsel (
        .ovr_en (ovr_en),
        .ovr_sel(ovr_sel),
        .cs_val (cs_q),
        .es_val (seg_es),
        .ss_val (seg_ss),
        .ds_val (seg_ds),
        .seg    (op_seg)
    );

    seg_ind_seq #(.OFF_W(OFF_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (take_ind),
        .start_far(br_far),
        .ptr_seg  (op_seg),
        .ptr_off  (br_off),
        .mem_ack  (mem_ack),
        .mem_rdata(mem_rdata),
        .mem_req  (mem_req),
        .mem_seg  (mem_seg),
        .mem_off  (mem_off),
        .busy     (busy),
        .load_ip  (seq_load_ip),
        .load_cs  (seq_load_cs),
        .new_ip   (seq_new_ip),
        .new_cs   (seq_new_cs)
    );

    seg_addr_gen #(.OFF_W(OFF_W), .PA_W(PA_W)) u_fetch_ag (
        .seg (cs_q),
        .off (ip_q),
        .phys(fetch_addr)
    );

    seg_addr_gen #(.OFF_W(OFF_W), .PA_W(PA_W)) u_op_ag (
        .seg (op_seg),
        .off (op_off),
        .phys(op_addr)
    );

    seg_addr_gen #(.OFF_W(OFF_W), .PA_W(PA_W)) u_mem_ag (
        .seg (mem_seg),
        .off (mem_off),
        .phys(mem_addr)
    );

    // Register outputs for observers
    always_comb begin
        cs_out = cs_q;
        ip_out = ip_q;
    end
endmodule

// File: rtl/seg_branch_chk.sv
// Property checker for seg_branch_unit, attached by bind below.
// Assumes the unit's port-level contract; reads ports only.
module seg_branch_chk #(
    parameter int LEN_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adv_valid,
    input logic [LEN_W-1:0] adv_len,
    input logic             br_valid,
    input logic             br_far,
    input logic             br_indirect,
    input logic [15:0]      br_off,
    input logic [15:0]      br_seg,
    input logic             mem_req,
    input logic [19:0]      mem_addr,
    input logic             mem_ack,
    input logic [19:0]      fetch_addr,
    input logic [15:0]      cs_out,
    input logic [15:0]      ip_out,
    input logic             busy
);
    logic [19:0] fetch_ref;

    // Independent fetch address reference
    always_comb fetch_ref = {cs_out, 4'h0} + {4'h0, ip_out};

    // R2
    fetch_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_addr == fetch_ref);

    // R4
    advance_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_valid && !br_valid && !busy) |=>
        (ip_out == 16'($past(ip_out) + 16'($past(adv_len))) && cs_out == $past(cs_out)));

    // R5
    near_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !busy && !br_far && !br_indirect) |=>
        (ip_out == $past(br_off) && cs_out == $past(cs_out)));

    // R6
    far_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !busy && br_far && !br_indirect) |=>
        (ip_out == $past(br_off) && cs_out == $past(br_seg)));

    // R9
    req_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_ack) |=> ($stable(cs_out) && $stable(ip_out)));
endmodule

bind seg_branch_unit seg_branch_chk #(.LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_valid  (adv_valid),
    .adv_len    (adv_len),
    .br_valid   (br_valid),
    .br_far     (br_far),
    .br_indirect(br_indirect),
    .br_off     (br_off),
    .br_seg     (br_seg),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .fetch_addr (fetch_addr),
    .cs_out     (cs_out),
    .ip_out     (ip_out),
    .busy       (busy)
);

// File: tb/tb_seg_branch_unit.sv
`timescale 1ns/100ps
// Self-checking bench: seeded random mix plus directed corners.
module tb_seg_branch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv_valid = 1'b0;
    logic [3:0]  adv_len = '0;
    logic        br_valid = 1'b0, br_far = 1'b0, br_indirect = 1'b0;
    logic [15:0] br_off = '0, br_seg = '0, op_off = '0;
    logic        ovr_en = 1'b0;
    logic [1:0]  ovr_sel = '0;
    logic [15:0] seg_es = '0, seg_ss = '0, seg_ds = '0;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        mem_req, busy;
    logic [19:0] mem_addr, fetch_addr, op_addr;
    logic [15:0] cs_out, ip_out;

    int n_chk = 0, n_bad = 0;
    logic [15:0] m_cs, m_ip;

    always #2.5 clk = ~clk;

    seg_branch_unit dut (
        .clk(clk), .rst_n(rst_n), .adv_valid(adv_valid), .adv_len(adv_len),
        .br_valid(br_valid), .br_far(br_far), .br_indirect(br_indirect),
        .br_off(br_off), .br_seg(br_seg), .op_off(op_off), .ovr_en(ovr_en),
        .ovr_sel(ovr_sel), .seg_es(seg_es), .seg_ss(seg_ss), .seg_ds(seg_ds),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .fetch_addr(fetch_addr), .op_addr(op_addr),
        .cs_out(cs_out), .ip_out(ip_out), .busy(busy)
    );

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    function automatic logic [15:0] op_seg_ref(input logic en, input logic [1:0] sel);
        if (!en) return seg_ds;
        case (sel)
            2'b00:   return seg_es;
            2'b01:   return m_cs;
            2'b10:   return seg_ss;
            default: return seg_ds;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_regs(input string req);
        check({req, " cs"}, 32'(cs_out), 32'(m_cs));
        check({req, " ip"}, 32'(ip_out), 32'(m_ip));
        check("R2 fetch", 32'(fetch_addr), 32'(phys(m_cs, m_ip)));
    endtask

    task automatic clear_req();
        br_valid = 1'b0; adv_valid = 1'b0; br_indirect = 1'b0; br_far = 1'b0;
    endtask

    task automatic rand_operand();
        seg_es = 16'($urandom); seg_ss = 16'($urandom); seg_ds = 16'($urandom);
        op_off = 16'($urandom); ovr_en = 1'($urandom); ovr_sel = 2'($urandom);
        #1;
        check("R3 op_addr", 32'(op_addr), 32'(phys(op_seg_ref(ovr_en, ovr_sel), op_off)));
    endtask

    // Wait ack_dly cycles with junk requests, then acknowledge with data
    task automatic serve(input logic [19:0] exp_addr, input int ack_dly, input logic [15:0] data);
        for (int k = 0; k < ack_dly; k++) begin
            check("R9 mem_req", 32'(mem_req), 32'd1);
            check("R9 mem_addr", 32'(mem_addr), 32'(exp_addr));
            br_valid = 1'b1; br_far = 1'($urandom); br_indirect = 1'($urandom);
            br_off = 16'($urandom); br_seg = 16'($urandom);
            adv_valid = 1'b1; adv_len = 4'($urandom);
            seg_ds = 16'($urandom);
            @(negedge clk);
            check_regs("R10 busy ignore");
        end
        clear_req();
        check("R9 mem_addr", 32'(mem_addr), 32'(exp_addr));
        mem_ack = 1'b1; mem_rdata = data;
        @(negedge clk);
        mem_ack = 1'b0; mem_rdata = 16'($urandom);
    endtask

    task automatic indirect(input logic far, input logic [15:0] poff, input int d0, input int d1);
        logic [15:0] pseg, w0, w1;
        string tag;
        tag = far ? "R8" : "R7";
        rand_operand();
        pseg = op_seg_ref(ovr_en, ovr_sel);
        w0 = 16'($urandom); w1 = 16'($urandom);
        br_valid = 1'b1; br_indirect = 1'b1; br_far = far; br_off = poff;
        @(negedge clk);
        clear_req();
        check("R9 busy", 32'(busy), 32'd1);
        serve(phys(pseg, poff), d0, w0);
        if (far) begin
            check_regs("R8 hold");
            check("R9 busy", 32'(busy), 32'd1);
            serve(phys(pseg, poff + 16'd2), d1, w1);
            m_cs = w1;
        end
        m_ip = w0;
        check_regs(tag);
        check("R9 idle", 32'(busy), 32'd0);
        check("R9 idle req", 32'(mem_req), 32'd0);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R9 watchdog act=hung exp=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_cs = 16'hFFFF; m_ip = 16'h0000;
        // R1 reset state
        check_regs("R1 reset");
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 mem_req", 32'(mem_req), 32'd0);

        // R4 advance wraps within 16 bits
        br_valid = 1'b1; br_far = 1'b0; br_off = 16'hFFFE;
        @(negedge clk); clear_req(); m_ip = 16'hFFFE; check_regs("R5 near");
        adv_valid = 1'b1; adv_len = 4'd5;
        @(negedge clk); clear_req(); m_ip = 16'h0003; check_regs("R4 wrap");

        // R6 far branch and R2 20-bit wrap of fetch address
        br_valid = 1'b1; br_far = 1'b1; br_seg = 16'hFFFF; br_off = 16'h0020;
        @(negedge clk); clear_req(); m_cs = 16'hFFFF; m_ip = 16'h0020;
        check_regs("R6 far");
        check("R2 wrap", 32'(fetch_addr), 32'h00010);

        // R11 branch wins over advance
        br_valid = 1'b1; br_far = 1'b0; br_off = 16'h1234; adv_valid = 1'b1; adv_len = 4'd7;
        @(negedge clk); clear_req(); m_ip = 16'h1234; check_regs("R11 priority");

        // R8 far indirect pointer at segment end, second word wraps inside it
        indirect(1'b1, 16'hFFFF, 2, 0);
        indirect(1'b0, 16'h0000, 0, 0);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int kind;
            kind = int'($urandom % 6);
            if (kind == 5) begin
                indirect(1'($urandom), 16'($urandom), int'($urandom % 4), int'($urandom % 4));
            end else begin
                rand_operand();
                br_off = 16'($urandom); br_seg = 16'($urandom); adv_len = 4'($urandom);
                br_indirect = 1'b0;
                case (kind)
                    1: begin adv_valid = 1'b1; m_ip = m_ip + 16'(adv_len); end
                    2: begin br_valid = 1'b1; br_far = 1'b0; m_ip = br_off; end
                    3: begin br_valid = 1'b1; br_far = 1'b1; m_ip = br_off; m_cs = br_seg; end
                    4: begin br_valid = 1'b1; adv_valid = 1'b1; br_far = 1'($urandom);
                             m_ip = br_off; if (br_far) m_cs = br_seg; end
                    default: ;
                endcase
                @(negedge clk);
                clear_req();
                case (kind)
                    1: check_regs("R4 adv");
                    2: check_regs("R5 near");
                    3: check_regs("R6 far");
                    4: check_regs("R11 both");
                    default: check_regs("R2 idle");
                endcase
            end
        end

        // R1 reset from a moved state
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; m_cs = 16'hFFFF; m_ip = 16'h0000;
        check_regs("R1 reset again");

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule